// File: doc/BRIEF.md
# Posted-Write Real-Time Clock with Alarm

This block is a memory-mapped real-time clock. A 32-bit seconds word and a fraction word form one time value. The fraction advances by one every clock cycle while the clock is running, and its carry advances the seconds word. A second pair of words holds an alarm time. When the running counter reaches that time, the block sets an alarm flag.

Software writes registers through a posted path. A write is accepted at once and then takes a fixed number of cycles to reach the timekeeping logic. Status flags report that the path is busy, that it is free for the next write, and whether the last write completed or failed. Status flags are cleared by writing ones to them. A single interrupt line combines the flags that software has enabled.

The counter does not run straight out of reset. Three things must be true first: the seconds word has been written at least once, the invalid flag has been cleared, and the enable bit is set.

Top module: `rtc_posted`

## Requirements
- R1: Word addresses are 0 seconds, 1 fraction, 2 alarm seconds, 3 alarm fraction, 4 control, 5 status and 6 interrupt enable. Reads are registered, so a value appears one cycle after its address. Control reads back only bit 3. Interrupt enable reads back only bits 9, 8, 7 and 4. Fraction words read back their low FRAC_W bits, zero-extended.
- R2: After reset, the values are as follows.
  - Status reads 0x202: write-next at bit 9 and invalid at bit 1.
  - Control, interrupt enable, seconds and fraction read 0.
  - Alarm seconds reads 0xFFFFFFFF.
  - irq is low.
- R3: A write accepted while the path is idle behaves as follows.
  - Write-busy (status bit 10) is high for COMMIT_LAT cycles, starting from the acceptance edge.
  - Write-next (bit 9) is the inverse of write-busy.
  - At the end of that window, the register takes the new value and write-complete (bit 8) is set.
- R4: A write that arrives while write-busy is high is dropped, leaving its target unchanged, and sets write-error (bit 7).
- R5: A write to address 7 changes no register. When it commits, it sets write-error and leaves write-complete clear.
- R6: Status bits 8, 7 and 4 clear when a status write with a one at that position commits, and not before. A status write that clears bit 8 does not set bit 8 again on completion.
- R7: The invalid flag (bit 1) clears only when a status write with both bit 1 and bit 0 set commits. A write with bit 1 alone leaves it set.
- R8: The counter runs only when control bit 3 is set, the seconds word has been written since reset, and the invalid flag is clear. While running, the fraction adds one per cycle modulo 2^FRAC_W. A fraction wrap adds one to seconds.
- R9: Alarm flag (bit 4) behaviour:
  - It sets one cycle after a running counter equals both alarm words.
  - An alarm-seconds value of all ones therefore matches only during the last second before seconds wraps.
  - Seconds wraps from all ones to zero.
- R10: irq is a register. It is high one cycle after any of status bits 9, 8, 7 or 4 is set together with the same bit of interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write request |
| wr_addr | input | 3 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read word address |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with FRAC_W = 4 and COMMIT_LAT = 4. A 4-bit fraction wraps every 16 cycles, so seconds carries can be seen within a short run. Loading all ones into seconds then brings the final-second alarm match and the wrap to zero within reach. The default fraction width of 32 would need billions of cycles to show either.

// File: rtl/rtc_posted_pkg.sv
package rtc_posted_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_SEC   = 3'd0;
  localparam logic [ADDR_W-1:0] A_FRAC  = 3'd1;
  localparam logic [ADDR_W-1:0] A_ASEC  = 3'd2;
  localparam logic [ADDR_W-1:0] A_AFRAC = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd4;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd5;
  localparam logic [ADDR_W-1:0] A_IEN   = 3'd6;

  localparam int unsigned B_RUN  = 3;
  localparam int unsigned B_BUSY = 10;
  localparam int unsigned B_NEXT = 9;
  localparam int unsigned B_DONE = 8;
  localparam int unsigned B_ERR  = 7;
  localparam int unsigned B_ALM  = 4;
  localparam int unsigned B_INV  = 1;
  localparam int unsigned B_SV   = 0;

  localparam logic [REG_W-1:0] IRQ_MASK = 32'h0000_0390;
endpackage

// File: rtl/rtc_post_seq.sv
module rtc_post_seq #(
  parameter int unsigned DW  = 32,
  parameter int unsigned AW  = 3,
  parameter int unsigned LAT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          busy,
  output logic          drop,
  output logic          cmt,
  output logic [AW-1:0] cmt_addr,
  output logic [DW-1:0] cmt_data
);
  localparam int unsigned CW = $clog2(LAT + 1);

  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      left     <= '0;
      cmt_addr <= '0;
      cmt_data <= '0;
    end else if (!busy && wr_en) begin
      busy     <= 1'b1;
      left     <= CW'(LAT - 1);
      cmt_addr <= wr_addr;
      cmt_data <= wr_data;
    end else if (busy) begin
      if (left == '0) busy <= 1'b0;
      else            left <= left - 1'b1;
    end
  end

  assign cmt  = busy && (left == '0);
  assign drop = wr_en && busy;

  assert_accept_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !busy) |=> busy);
  assert_commit_ends_R3: assert property (@(posedge clk) disable iff (rst)
    cmt |=> !busy);
  assert_hold_payload_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && !cmt) |=> ($stable(cmt_addr) && $stable(cmt_data)));
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper #(
  parameter int unsigned SW = 32,
  parameter int unsigned FW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          sec_wr,
  input  logic          frac_wr,
  input  logic [SW-1:0] wdata,
  input  logic [SW-1:0] alm_sec,
  input  logic [FW-1:0] alm_frac,
  output logic [SW-1:0] sec,
  output logic [FW-1:0] frac,
  output logic          hit
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sec  <= '0;
      frac <= '0;
    end else begin
      if (sec_wr)                 sec <= wdata;
      else if (run && (&frac))    sec <= sec + 1'b1;
      if (frac_wr)                frac <= wdata[FW-1:0];
      else if (run)               frac <= frac + 1'b1;
    end
  end

  assign hit = run && (sec == alm_sec) && (frac == alm_frac);

  assert_stopped_R8: assert property (@(posedge clk) disable iff (rst)
    (!run && !sec_wr && !frac_wr) |=> ($stable(sec) && $stable(frac)));
  assert_frac_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    (run && !frac_wr && (&frac)) |=> (frac == '0));
endmodule

// File: rtl/rtc_flags.sv
module rtc_flags (
  input  logic       clk,
  input  logic       rst,
  input  logic       drop,
  input  logic       good_cmt,
  input  logic       bad_cmt,
  input  logic [4:0] clr,
  input  logic       hit,
  output logic       done,
  output logic       err,
  output logic       alm,
  output logic       inv,
  output logic       sv
);
  // clr = {done, err, alarm, invalid, violation} ones from a committing status write
  always_ff @(posedge clk) begin
    if (rst) begin
      done <= 1'b0;
      err  <= 1'b0;
      alm  <= 1'b0;
      inv  <= 1'b1;
      sv   <= 1'b0;
    end else begin
      done <= (done & ~clr[4]) | (good_cmt & ~clr[4]);
      err  <= (err & ~clr[3]) | drop | bad_cmt;
      alm  <= (alm & ~clr[2]) | hit;
      if (clr[1] && clr[0]) inv <= 1'b0;
      sv   <= sv & ~clr[0];
    end
  end

  assert_drop_err_R4: assert property (@(posedge clk) disable iff (rst)
    drop |=> err);
  assert_bad_err_R5: assert property (@(posedge clk) disable iff (rst)
    bad_cmt |=> err);
  assert_inv_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (inv && !(clr[1] && clr[0])) |=> inv);
  assert_alarm_set_R9: assert property (@(posedge clk) disable iff (rst)
    hit |=> alm);
endmodule

// File: rtl/rtc_posted.sv
module rtc_posted
  import rtc_posted_pkg::*;
#(
  parameter int unsigned FRAC_W     = 32,
  parameter int unsigned COMMIT_LAT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic              irq
);
  logic              busy, drop, cmt;
  logic [ADDR_W-1:0] cmt_addr;
  logic [REG_W-1:0]  cmt_data;
  logic              run_en, seen_sec;
  logic [REG_W-1:0]  ien, asec;
  logic [FRAC_W-1:0] afrac;
  logic [REG_W-1:0]  sec;
  logic [FRAC_W-1:0] frac;
  logic              hit, run;
  logic              done, err, alm, inv, sv;
  logic              addr_ok, stat_wr;
  logic [4:0]        st_clr;
  logic [REG_W-1:0]  stat_word;

  rtc_post_seq #(.DW(REG_W), .AW(ADDR_W), .LAT(COMMIT_LAT)) u_post (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .drop(drop), .cmt(cmt), .cmt_addr(cmt_addr), .cmt_data(cmt_data)
  );

  assign addr_ok = (cmt_addr <= A_IEN);
  assign stat_wr = cmt && (cmt_addr == A_STAT);
  assign st_clr  = stat_wr ? {cmt_data[B_DONE], cmt_data[B_ERR], cmt_data[B_ALM],
                              cmt_data[B_INV], cmt_data[B_SV]} : 5'd0;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_en   <= 1'b0;
      seen_sec <= 1'b0;
      ien      <= '0;
      asec     <= '1;
      afrac    <= '0;
    end else if (cmt) begin
      case (cmt_addr)
        A_SEC:   seen_sec <= 1'b1;
        A_ASEC:  asec     <= cmt_data;
        A_AFRAC: afrac    <= cmt_data[FRAC_W-1:0];
        A_CTRL:  run_en   <= cmt_data[B_RUN];
        A_IEN:   ien      <= cmt_data & IRQ_MASK;
        default: ;
      endcase
    end
  end

  assign run = run_en && seen_sec && !inv;

  rtc_timekeeper #(.SW(REG_W), .FW(FRAC_W)) u_time (
    .clk(clk), .rst(rst), .run(run),
    .sec_wr(cmt && (cmt_addr == A_SEC)), .frac_wr(cmt && (cmt_addr == A_FRAC)),
    .wdata(cmt_data), .alm_sec(asec), .alm_frac(afrac),
    .sec(sec), .frac(frac), .hit(hit)
  );

  rtc_flags u_flags (
    .clk(clk), .rst(rst), .drop(drop),
    .good_cmt(cmt && addr_ok), .bad_cmt(cmt && !addr_ok),
    .clr(st_clr), .hit(hit),
    .done(done), .err(err), .alm(alm), .inv(inv), .sv(sv)
  );

  always_comb begin
    stat_word         = '0;
    stat_word[B_BUSY] = busy;
    stat_word[B_NEXT] = !busy;
    stat_word[B_DONE] = done;
    stat_word[B_ERR]  = err;
    stat_word[B_ALM]  = alm;
    stat_word[B_INV]  = inv;
    stat_word[B_SV]   = sv;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      irq <= |(ien & stat_word & IRQ_MASK);
      case (rd_addr)
        A_SEC:   rd_data <= sec;
        A_FRAC:  rd_data <= REG_W'(frac);
        A_ASEC:  rd_data <= asec;
        A_AFRAC: rd_data <= REG_W'(afrac);
        A_CTRL:  rd_data <= REG_W'(run_en) << B_RUN;
        A_STAT:  rd_data <= stat_word;
        A_IEN:   rd_data <= ien;
        default: rd_data <= '0;
      endcase
    end
  end

  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (rst)
    (ien == '0) |=> !irq);
  assert_no_run_unseen_R8: assert property (@(posedge clk) disable iff (rst)
    !seen_sec |-> !run);
  assert_cmt_busy_R3: assert property (@(posedge clk) disable iff (rst)
    cmt |-> busy);
endmodule

// File: tb/rtc_posted_bench.sv
module rtc_posted_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;
  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  rtc_posted #(.FRAC_W(4), .COMMIT_LAT(4)) u_rtc_posted (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  // {address, write data, expected read-back}
  localparam logic [66:0] TBL [7] = '{
    {3'd2, 32'h0000ABCD, 32'h0000ABCD},
    {3'd3, 32'h12345678, 32'h00000008},
    {3'd4, 32'hFFFFFFF7, 32'h00000000},
    {3'd1, 32'h00000009, 32'h00000009},
    {3'd0, 32'h00C0FFEE, 32'h00C0FFEE},
    {3'd6, 32'hFFFFFFFF, 32'h00000390},
    {3'd6, 32'h00000000, 32'h00000000}
  };

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_wait(input logic [2:0] a, input logic [31:0] d);
    wr(a, d);
    repeat (6) @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  initial begin
    #(20ns * 100000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] a, b;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R2 reset state
    rd(3'd5, a); chk("R2 status", a, 32'h202);
    rd(3'd4, a); chk("R2 control", a, 0);
    rd(3'd6, a); chk("R2 ien", a, 0);
    rd(3'd0, a); chk("R2 seconds", a, 0);
    rd(3'd2, a); chk("R2 alarm seconds", a, 32'hFFFFFFFF);
    chk("R2 irq", {31'b0, irq}, 0);

    // R7 invalid flag needs both bits
    wr_wait(3'd5, 32'h2);
    rd(3'd5, a); chk("R7 invalid kept", a, 32'h302);
    wr_wait(3'd5, 32'h3);
    rd(3'd5, a); chk("R7 invalid cleared", a, 32'h300);

    // R8 enabled but seconds never written: no counting
    wr_wait(3'd4, 32'h8);
    rd(3'd1, a); repeat (7) @(negedge clk); rd(3'd1, b);
    chk("R8 held until seconds written", b, a);

    // R8 counting and carry
    wr_wait(3'd0, 32'h10);
    rd(3'd1, a); repeat (7) @(negedge clk); rd(3'd1, b);
    chk("R8 fraction delta", (b - a) & 32'hF, 32'h8);
    rd(3'd0, a); repeat (15) @(negedge clk); rd(3'd0, b);
    chk("R8 seconds carry", b, a + 1);
    wr_wait(3'd4, 32'h0);
    rd(3'd1, a); repeat (7) @(negedge clk); rd(3'd1, b);
    chk("R8 disabled holds", b, a);

    // R1 register map table
    for (int i = 0; i < 7; i++) begin
      wr_wait(TBL[i][66:64], TBL[i][63:32]);
      rd(TBL[i][66:64], a);
      chk($sformatf("R1 entry %0d", i), a, TBL[i][31:0]);
    end

    // R6 clearing write-complete
    wr_wait(3'd5, 32'h100);
    rd(3'd5, a); chk("R6 complete cleared", a, 32'h200);

    // R3 busy window and completion
    wr(3'd3, 32'h2);
    rd(3'd5, a); chk("R3 busy at start", a, 32'h400);
    repeat (2) @(negedge clk);
    rd(3'd5, a); chk("R3 busy at last cycle", a, 32'h400);
    rd(3'd5, a); chk("R3 complete after window", a, 32'h300);
    rd(3'd3, a); chk("R3 value committed", a, 32'h2);

    // R4 dropped write while busy
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd2; wr_data = 32'h55;
    @(negedge clk);
    wr_data = 32'h66;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (6) @(negedge clk);
    rd(3'd5, a); chk("R4 error flag", a & 32'h80, 32'h80);
    rd(3'd2, a); chk("R4 dropped write", a, 32'h55);

    // R6 error clears only at commit of the status write
    wr(3'd5, 32'h80);
    rd(3'd5, a); chk("R6 error still set", a & 32'h80, 32'h80);
    repeat (3) @(negedge clk);
    rd(3'd5, a); chk("R6 error cleared", a & 32'h80, 32'h0);

    // R5 invalid address
    wr_wait(3'd5, 32'h180);
    wr_wait(3'd7, 32'h1234);
    rd(3'd5, a); chk("R5 bad address", a, 32'h280);

    // R10 interrupt
    wr_wait(3'd6, 32'h80);
    chk("R10 irq on error", {31'b0, irq}, 1);
    wr_wait(3'd5, 32'h80);
    chk("R10 irq dropped", {31'b0, irq}, 0);

    // R9 alarm at final second and wrap
    wr_wait(3'd6, 32'h10);
    wr_wait(3'd0, 32'hFFFFFFFF);
    wr_wait(3'd1, 32'h0);
    wr_wait(3'd2, 32'hFFFFFFFF);
    wr_wait(3'd3, 32'h5);
    rd(3'd5, a); chk("R9 no alarm while stopped", a & 32'h10, 0);
    chk("R10 irq low before alarm", {31'b0, irq}, 0);
    wr(3'd4, 32'h8);
    repeat (20) @(negedge clk);
    rd(3'd0, a); chk("R9 seconds wrapped", a, 32'h0);
    rd(3'd5, a); chk("R9 alarm flag", a & 32'h10, 32'h10);
    chk("R10 irq on alarm", {31'b0, irq}, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule